// File: doc/BRIEF.md
# Pattern-Filtered ISI Tap Estimator

This block turns eye-centre level histograms into coefficient codes for a two-postcursor look-ahead decision feedback equalizer. A histogram engine upstream samples the candidate signals at the eye-centre phase. It applies three data-pattern filters and captures one histogram for the upper eye level and one for the lower eye level under each filter. The engine streams each histogram into this block as (level bin, hit count) beats.

For each histogram the block forms a weighted mean level, using a shared sequential divider. Once six histograms have arrived, it forms three differential magnitudes, upper mean minus lower mean:

- M1 from the all-same pattern, which equals 2(a0+a1+a2).
- M2 from the second-postcursor-flipped pattern, which equals 2(a0+a1-a2).
- M3 from the first-postcursor-flipped pattern, which equals 2(a0-a1+a2).

From these it solves for the main cursor a0 and the postcursors a1 and a2. It then publishes four saturated 5-bit offset codes, one per look-ahead candidate path, and pulses a strobe.

The codes sit at their minimum value until the first full measurement set has been processed. The upstream engine must hold a beat while the ready output is low.

Top module: `tap_estimator`

## Requirements
- R1: After reset, all four tap codes are 0, the main-cursor output is 0, codes_valid is 0 and hist_ready is 1.
- R2: The mean of one histogram is floor(sum(bin*count)/sum(count)), computed over every accepted beat up to and including the beat with hist_last. A histogram whose counts total zero has mean 0.
- R3: Histograms are consumed in a fixed order of six slots: upper then lower for M1, upper then lower for M2, upper then lower for M3. Each magnitude is the upper mean minus the lower mean, as a signed value.
- R4: a2 = floor((M1-M2)/4), a1 = floor((M1-M3)/4) and a0 = floor((M2+M3)/4). a0 appears on main_cursor in two's complement.
- R5: The candidate with index c = {b1,b2} occupies tap_codes[5c+4:5c]. b1 is the first-postcursor bit and b2 is the second. Its code is s1*a1 + s2*a2 + 16, where s is +1 for a bit of 1 and -1 for a bit of 0.
- R6: A code whose biased value falls below 0 is output as 0, and one above 31 is output as 31.
- R7: codes_valid is a single-cycle pulse, raised once after the sixth histogram's mean is formed. tap_codes and main_cursor change only in a cycle where codes_valid is 1.
- R8: hist_ready is low while a mean is being divided. A beat presented while hist_ready is low is ignored and has no effect on any result.
- R9: Counts and weighted sums accumulate across any number of beats, and hist_last closes the histogram.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hist_valid | input | 1 | A histogram beat is present |
| hist_bin | input | BIN_W (6) | Level bin of the beat, unsigned |
| hist_count | input | CNT_W (10) | Hit count for that bin |
| hist_last | input | 1 | Final beat of the current histogram |
| hist_ready | output | 1 | Block accepts a beat this cycle |
| tap_codes | output | 4*CODE_W (20) | Four offset-binary candidate codes, index {b1,b2} |
| main_cursor | output | BIN_W+3 (9) | Signed main-cursor estimate a0 |
| codes_valid | output | 1 | One-cycle strobe when codes are updated |

## Verification
The main sweep builds eye levels from known cursor triples. a0 is held fixed while a1 and a2 each walk from negative to positive values, so that each of the four codes sees every sign combination. Distinct magnitudes for the three filters show whether the slots are taken in order and whether the solve equations pair the right magnitudes.

Each histogram spreads its hits over three neighbouring bins with weights that vary by vector. This makes the floor of the weighted mean matter, which a single-bin histogram would hide. One vector drives the postcursors far beyond the code range to reach both saturation ends. Another supplies an empty histogram, which checks the zero-total rule. On alternate vectors a large junk beat is driven while the block is busy; any effect it had would appear in the final codes.

// File: rtl/tap_est_pkg.sv
// Shared constants and types for the tap estimator.
// Assumes two postcursors, so four look-ahead candidates and six level histograms.
package tap_est_pkg;
    localparam int NUM_SLOTS = 6;
    localparam int NUM_CAND  = 4;
    typedef logic [2:0] slot_t;
    localparam slot_t LAST_SLOT = slot_t'(NUM_SLOTS - 1);
endpackage

// File: rtl/seq_divider.sv
// Restoring unsigned divider: one quotient bit per cycle, N_W cycles per divide.
// Assumes start is only honoured while idle. A zero divisor yields quotient 0.
module seq_divider #(
    parameter int N_W = 24,
    parameter int D_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           busy,
    output logic           done,
    output logic [N_W-1:0] quot
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [D_W-1:0]   rem;
    logic [N_W-1:0]   num;
    logic [N_W-1:0]   q;
    logic [N_W-1:0]   dvd_q;
    logic [D_W-1:0]   dsr;
    logic [CNT_W-1:0] cnt;
    logic [D_W:0]     trial;
    logic [D_W:0]     diff;

    // Next partial remainder and trial subtraction; diff MSB set means a borrow.
    always_comb begin
        trial = {rem, num[N_W-1]};
        diff  = trial - {1'b0, dsr};
    end

    // Load operands on start, then shift one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0; num <= '0; q <= '0; dvd_q <= '0; dsr <= '0;
            cnt <= '0; busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem   <= '0;
                num   <= dividend;
                dvd_q <= dividend;
                dsr   <= divisor;
                q     <= '0;
                cnt   <= CNT_W'(N_W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (!diff[D_W]) begin
                    rem <= diff[D_W-1:0];
                    q   <= {q[N_W-2:0], 1'b1};
                end else begin
                    rem <= trial[D_W-1:0];
                    q   <= {q[N_W-2:0], 1'b0};
                end
                num <= num << 1;
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = (dsr == '0) ? '0 : q;

    // R2: a finished quotient never overshoots the dividend.
    assert_quot_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (({{D_W{1'b0}}, quot} * {{N_W{1'b0}}, dsr}) <= {{D_W{1'b0}}, dvd_q}));

    // R8: an accepted start makes the divider busy on the next cycle.
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/level_accum.sv
// Accumulates the weighted bin sum and the total count of one histogram.
// Presents the final totals combinationally on the closing beat and then clears.
module level_accum #(
    parameter int BIN_W = 6,
    parameter int CNT_W = 10,
    parameter int ACC_W = 24,
    parameter int TOT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_ok,
    input  logic [BIN_W-1:0] bin,
    input  logic [CNT_W-1:0] count,
    input  logic             last,
    output logic             close,
    output logic [ACC_W-1:0] sum_final,
    output logic [TOT_W-1:0] tot_final
);
    logic [ACC_W-1:0] sum_q;
    logic [TOT_W-1:0] tot_q;

    // Running totals including the beat on the input this cycle.
    always_comb begin
        sum_final = sum_q + ACC_W'(bin * count);
        tot_final = tot_q + TOT_W'(count);
        close     = beat_ok && last;
    end

    // Keep totals between beats; clear once the histogram closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            tot_q <= '0;
        end else if (beat_ok) begin
            sum_q <= last ? '0 : sum_final;
            tot_q <= last ? '0 : tot_final;
        end
    end

    // R8: with no accepted beat the totals do not move.
    assert_hold_totals_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_ok |=> ($stable(sum_q) && $stable(tot_q)));
endmodule

// File: rtl/tap_solver.sv
// Combinational cursor solve and code mapping from six stored mean levels.
// Slot order is upper/lower for M1, M2, M3. Codes are offset binary and saturated.
module tap_solver #(
    parameter int BIN_W  = 6,
    parameter int CODE_W = 5
) (
    input  logic [6*BIN_W-1:0]        means,
    output logic [4*CODE_W-1:0]       codes,
    output logic signed [BIN_W+2:0]   a0
);
    localparam int W    = BIN_W + 3;
    localparam int BIAS = 2 ** (CODE_W - 1);
    localparam int MAXC = 2 ** CODE_W - 1;

    logic signed [W-1:0] mag [3];
    logic signed [W-1:0] a1, a2;

    // Differential magnitudes, then the three-equation solve with floor shifts.
    always_comb begin
        for (int k = 0; k < 3; k++) begin
            mag[k] = $signed(W'(means[(2*k)*BIN_W +: BIN_W]))
                   - $signed(W'(means[(2*k+1)*BIN_W +: BIN_W]));
        end
        a2 = (mag[0] - mag[1]) >>> 2;
        a1 = (mag[0] - mag[2]) >>> 2;
        a0 = (mag[1] + mag[2]) >>> 2;
    end

    for (genvar c = 0; c < 4; c++) begin : g_cand
        logic signed [W-1:0] biased;
        // Sign-combine the postcursors for candidate {b1,b2}, bias and clamp.
        always_comb begin
            biased = ((c >= 2) ? a1 : -a1) + ((c % 2 == 1) ? a2 : -a2) + W'(BIAS);
            if (biased < 0)
                codes[c*CODE_W +: CODE_W] = '0;
            else if (biased > W'(MAXC))
                codes[c*CODE_W +: CODE_W] = CODE_W'(MAXC);
            else
                codes[c*CODE_W +: CODE_W] = biased[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/tap_estimator.sv
// Top level: takes six histograms in slot order, averages each, solves and publishes codes.
// Assumes the histogram source holds a beat while hist_ready is low.
module tap_estimator
    import tap_est_pkg::*;
#(
    parameter int BIN_W  = 6,
    parameter int CNT_W  = 10,
    parameter int ACC_W  = 24,
    parameter int TOT_W  = 16,
    parameter int CODE_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hist_valid,
    input  logic [BIN_W-1:0]          hist_bin,
    input  logic [CNT_W-1:0]          hist_count,
    input  logic                      hist_last,
    output logic                      hist_ready,
    output logic [4*CODE_W-1:0]       tap_codes,
    output logic signed [BIN_W+2:0]   main_cursor,
    output logic                      codes_valid
);
    logic                         beat_ok, close, div_busy, div_done;
    logic [ACC_W-1:0]             sum_final, quot;
    logic [TOT_W-1:0]             tot_final;
    logic [NUM_SLOTS*BIN_W-1:0]   means_q;
    logic [4*CODE_W-1:0]          codes_c;
    logic signed [BIN_W+2:0]      a0_c;
    slot_t                        slot;
    logic                         solve_go;

    assign hist_ready = !div_busy;
    assign beat_ok    = hist_valid && hist_ready;

    level_accum #(.BIN_W(BIN_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .TOT_W(TOT_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .beat_ok(beat_ok), .bin(hist_bin), .count(hist_count),
        .last(hist_last), .close(close), .sum_final(sum_final), .tot_final(tot_final));

    seq_divider #(.N_W(ACC_W), .D_W(TOT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(close), .dividend(sum_final), .divisor(tot_final),
        .busy(div_busy), .done(div_done), .quot(quot));

    tap_solver #(.BIN_W(BIN_W), .CODE_W(CODE_W)) u_solve (
        .means(means_q), .codes(codes_c), .a0(a0_c));

    // Store each finished mean into its slot and flag a solve after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            means_q  <= '0;
            slot     <= '0;
            solve_go <= 1'b0;
        end else begin
            solve_go <= 1'b0;
            if (div_done) begin
                means_q[slot*BIN_W +: BIN_W] <= quot[BIN_W-1:0];
                if (slot == LAST_SLOT) begin
                    slot     <= '0;
                    solve_go <= 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    // Register the solved codes and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_codes   <= '0;
            main_cursor <= '0;
            codes_valid <= 1'b0;
        end else begin
            codes_valid <= solve_go;
            if (solve_go) begin
                tap_codes   <= codes_c;
                main_cursor <= a0_c;
            end
        end
    end

    // R2: a weighted mean never exceeds the largest bin index.
    assert_mean_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> (quot[ACC_W-1:BIN_W] == '0));

    // R7: the strobe lasts one cycle.
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        codes_valid |=> !codes_valid);

    // R7: outputs hold whenever no strobe is shown.
    assert_hold_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !codes_valid |-> ($stable(tap_codes) && $stable(main_cursor)));

    // R3: the slot index stays inside the six-slot sequence.
    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST_SLOT);
endmodule

// File: tb/tap_estimator_bench.sv
// Sweeps cursor triples, streams six histograms per vector, checks codes against arithmetic.
module tap_estimator_bench;
    localparam int BIN_W = 6, CNT_W = 10, CODE_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hist_valid = 1'b0, hist_last = 1'b0;
    logic [BIN_W-1:0] hist_bin = '0;
    logic [CNT_W-1:0] hist_count = '0;
    logic hist_ready, codes_valid;
    logic [4*CODE_W-1:0] tap_codes;
    logic signed [BIN_W+2:0] main_cursor;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tap_estimator u_tap_estimator (
        .clk(clk), .rst_n(rst_n), .hist_valid(hist_valid), .hist_bin(hist_bin),
        .hist_count(hist_count), .hist_last(hist_last), .hist_ready(hist_ready),
        .tap_codes(tap_codes), .main_cursor(main_cursor), .codes_valid(codes_valid));

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic beat(int b, int c, bit last);
        @(negedge clk);
        while (!hist_ready) @(negedge clk);
        hist_valid = 1'b1; hist_bin = BIN_W'(b); hist_count = CNT_W'(c); hist_last = last;
        @(negedge clk);
        hist_valid = 1'b0; hist_last = 1'b0;
    endtask

    // Send one three-beat histogram around level lv; return its expected mean (R2, R9).
    task automatic send_hist(int lv, int w0, int w1, int w2, bit junk, output int mean);
        int s, t;
        beat(lv - 1, w0, 1'b0);
        beat(lv, w1, 1'b0);
        beat(lv + 1, w2, 1'b1);
        s = (lv - 1) * w0 + lv * w1 + (lv + 1) * w2;
        t = w0 + w1 + w2;
        mean = (t == 0) ? 0 : s / t;
        if (junk) begin
            check("R8 ready low while dividing", int'(hist_ready), 0);
            hist_valid = 1'b1; hist_bin = '1; hist_count = '1; hist_last = 1'b1;
            @(negedge clk);
            hist_valid = 1'b0; hist_last = 1'b0;
        end
    endtask

    function automatic int sat(int v);
        return (v < 0) ? 0 : (v > 31) ? 31 : v;
    endfunction

    // Run one vector: levels from (c0,c1,c2), optional empty first histogram.
    task automatic run_vec(int v, int c0, int c1, int c2, bit empty_first);
        int lvl[3], mu[6], m[3], a0, a1, a2, w0, w1, w2, got, wait_n;
        lvl[0] = c0 + c1 + c2; lvl[1] = c0 + c1 - c2; lvl[2] = c0 - c1 + c2;
        for (int k = 0; k < 6; k++) begin
            w0 = (v * 7 + k) % 5; w1 = 3 + (v + k) % 4; w2 = (v * 3 + 2 * k) % 6;
            if (empty_first && k == 0) begin w0 = 0; w1 = 0; w2 = 0; end
            send_hist((k % 2 == 0) ? 32 + lvl[k/2] : 32 - lvl[k/2], w0, w1, w2,
                      (v % 2 == 1) && (k % 3 == 0), got);
            mu[k] = got;
        end
        for (int k = 0; k < 3; k++) m[k] = mu[2*k] - mu[2*k+1];   // R3
        a2 = (m[0] - m[1]) >>> 2; a1 = (m[0] - m[2]) >>> 2; a0 = (m[1] + m[2]) >>> 2; // R4
        wait_n = 0;
        while (!codes_valid && wait_n < 200) begin @(negedge clk); wait_n++; end
        check("R7 strobe seen", int'(codes_valid), 1);
        check("R4 main cursor", int'(main_cursor), a0);
        for (int c = 0; c < 4; c++) begin
            int e = ((c >= 2) ? a1 : -a1) + ((c % 2 == 1) ? a2 : -a2) + 16;
            check("R5 R6 candidate code", int'(tap_codes[c*CODE_W +: CODE_W]), sat(e));
        end
        @(negedge clk);
        check("R7 strobe single cycle", int'(codes_valid), 0);
    endtask

    initial begin
        int cyc = 0;
        while (!finished && cyc < 150000) begin @(posedge clk); cyc++; end
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int v = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 codes at reset", int'(tap_codes), 0);
        check("R1 cursor at reset", int'(main_cursor), 0);
        check("R1 strobe at reset", int'(codes_valid), 0);
        check("R1 ready at reset", int'(hist_ready), 1);
        for (int p1 = -3; p1 <= 6; p1++) begin
            for (int p2 = -3; p2 <= 6; p2++) begin
                run_vec(v, 8, p1, p2, 1'b0);
                v++;
            end
        end
        run_vec(v, 4, 14, 12, 1'b0);   // R6 saturation both ends
        v++;
        run_vec(v, 6, 2, -1, 1'b1);    // R2 empty histogram gives mean 0
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule